// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router for Two Cores

This block collects a vector of level-sensitive, active-high interrupt sources and routes them to two processor cores. Each core has two lines: a normal interrupt line and a machine-check line. Each line has its own enable mask, so there are four masks in all. A line is asserted while any source that its mask enables is high. The block does not arbitrate between the lines. A single source can therefore raise every line at once when several masks enable it.

Software reaches the block through a plain register bus that reads and writes 32-bit words. The bus gives access to a read-only view of the synchronized source levels, to the four masks, and to a read-only word that names the highest-numbered enabled source pending for core 0. No source is ever acknowledged. A line drops only when its source goes low or its mask bit is cleared.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset, all four masks read as zero, every output line is low, and the pending-index word reads zero.
- R2: Offset 0x00 reads the source levels three clock edges after they are applied (two synchronizer flops, then the status flop); writes to 0x00 change nothing.
- R3: The core interrupt masks sit at 0x10 (core 0) and 0x14 (core 1), and the machine-check masks at 0x18 (core 0) and 0x1C (core 1). Each reads back the last value written to it.
- R4: `core_irq_o[n]` equals the OR of (status AND interrupt mask n), registered, so a mask write shows on the line one edge after the write edge.
- R5: `core_mchk_o[n]` equals the OR of (status AND machine-check mask n), with the same timing as R4.
- R6: When every mask enables a source, that source drives all four lines, and they all change on the same edge.
- R7: Offset 0x20 reads bit 5 = valid and bits 4:0 = the index of the highest-numbered set bit of (status AND core 0 interrupt mask). The word is registered with the same timing as R4, and reads zero when no enabled source is pending.
- R8: Reads from any offset not listed above return zero, and writes to such offsets leave every mask unchanged.
- R9: A line stays high for as long as its enabled source is high, with no acknowledge. It falls four edges after the source falls, or two edges after the mask write that clears its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Asynchronous level interrupt sources |
| bus_addr | input | AW | Register byte offset |
| bus_we | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| core_irq_o | output | NCORE | Normal interrupt line per core |
| core_mchk_o | output | NCORE | Machine-check line per core |

## Verification
Two things can land on the same update edge. One is a new source level arriving from the synchronizer. The other is a mask write that re-routes that source. Both feed the same output flops and the same pending-index flop. The bench provokes this by routing one source through all four masks and changing it. It also writes masks while sources are held. It then judges each line and the index word one edge before the expected update and again at that edge. This shows the four lines and the index all move together, on the correct cycle, with none of them taking priority over another.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
    // Register byte offsets; the per-core masks are laid out with a fixed stride.
    localparam int ADR_STATUS    = 'h00;
    localparam int ADR_IRQ_BASE  = 'h10;
    localparam int ADR_MCHK_BASE = 'h18;
    localparam int ADR_TOP       = 'h20;
    localparam int ADR_STRIDE    = 4;
endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] status_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] cap;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.s1  = async_i;
        sync_d.s2  = sync_q.s1;
        sync_d.cap = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign status_o = sync_q.cap;
endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
    import lvl_irq_pkg::*;
#(
    parameter int NSRC  = 32,
    parameter int NCORE = 2,
    parameter int AW    = 8,
    parameter int DW    = 32,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [AW-1:0]                bus_addr,
    input  logic                         bus_we,
    input  logic [DW-1:0]                bus_wdata,
    input  logic [NSRC-1:0]              status_i,
    input  logic                         top_valid_i,
    input  logic [IDX_W-1:0]             top_idx_i,
    output logic [NCORE-1:0][NSRC-1:0]   irq_mask_o,
    output logic [NCORE-1:0][NSRC-1:0]   mchk_mask_o,
    output logic [DW-1:0]                bus_rdata
);
    typedef struct packed {
        logic [NCORE-1:0][NSRC-1:0] irq;
        logic [NCORE-1:0][NSRC-1:0] mchk;
    } mask_t;

    mask_t mask_d, mask_q;

    function automatic logic [AW-1:0] irq_adr(input int c);
        return AW'(ADR_IRQ_BASE + ADR_STRIDE * c);
    endfunction

    function automatic logic [AW-1:0] mchk_adr(input int c);
        return AW'(ADR_MCHK_BASE + ADR_STRIDE * c);
    endfunction

    // Next-state: only exact mask offsets are writable; everything else is dropped.
    always_comb begin
        mask_d = mask_q;
        if (bus_we) begin
            for (int c = 0; c < NCORE; c++) begin
                if (bus_addr == irq_adr(c))  mask_d.irq[c]  = bus_wdata[NSRC-1:0];
                if (bus_addr == mchk_adr(c)) mask_d.mchk[c] = bus_wdata[NSRC-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // Read mux: unmatched offsets fall through to zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADR_STATUS)) bus_rdata = DW'(status_i);
        if (bus_addr == AW'(ADR_TOP))    bus_rdata = DW'({top_valid_i, top_idx_i});
        for (int c = 0; c < NCORE; c++) begin
            if (bus_addr == irq_adr(c))  bus_rdata = DW'(mask_q.irq[c]);
            if (bus_addr == mchk_adr(c)) bus_rdata = DW'(mask_q.mchk[c]);
        end
    end

    assign irq_mask_o  = mask_q.irq;
    assign mchk_mask_o = mask_q.mchk;
endmodule

// File: rtl/lvl_irq_prio.sv
module lvl_irq_prio #(
    parameter int NSRC = 32,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  pend_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // Ascending scan: the last hit, i.e. the highest-numbered bit, wins.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router #(
    parameter int NSRC  = 32,
    parameter int NCORE = 2,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic [NCORE-1:0] core_irq_o,
    output logic [NCORE-1:0] core_mchk_o
);
    localparam int IDX_W = $clog2(NSRC);

    typedef struct packed {
        logic [NCORE-1:0] irq;
        logic [NCORE-1:0] mchk;
        logic             top_valid;
        logic [IDX_W-1:0] top_idx;
    } out_t;

    logic [NSRC-1:0]            status_q;
    logic [NCORE-1:0][NSRC-1:0] irq_mask;
    logic [NCORE-1:0][NSRC-1:0] mchk_mask;
    logic                       prio_valid;
    logic [IDX_W-1:0]           prio_idx;
    logic                       top_valid_q;
    logic [IDX_W-1:0]           top_idx_q;
    out_t                       out_d, out_q;

    lvl_irq_sync #(.W(NSRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_i  (src_i),
        .status_o (status_q)
    );

    lvl_irq_regs #(.NSRC(NSRC), .NCORE(NCORE), .AW(AW), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .status_i    (status_q),
        .top_valid_i (top_valid_q),
        .top_idx_i   (top_idx_q),
        .irq_mask_o  (irq_mask),
        .mchk_mask_o (mchk_mask),
        .bus_rdata   (bus_rdata)
    );

    lvl_irq_prio #(.NSRC(NSRC)) u_prio (
        .pend_i  (status_q & irq_mask[0]),
        .valid_o (prio_valid),
        .idx_o   (prio_idx)
    );

    always_comb begin
        out_d = out_q;
        for (int c = 0; c < NCORE; c++) begin
            out_d.irq[c]  = |(status_q & irq_mask[c]);
            out_d.mchk[c] = |(status_q & mchk_mask[c]);
        end
        out_d.top_valid = prio_valid;
        out_d.top_idx   = prio_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign core_irq_o  = out_q.irq;
    assign core_mchk_o = out_q.mchk;
    assign top_valid_q = out_q.top_valid;
    assign top_idx_q   = out_q.top_idx;
endmodule

// File: rtl/lvl_irq_router_chk.sv
module lvl_irq_router_chk #(
    parameter int NSRC  = 32,
    parameter int NCORE = 2,
    localparam int IDX_W = $clog2(NSRC)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NSRC-1:0]            src_i,
    input logic [NSRC-1:0]            status_q,
    input logic [NCORE-1:0][NSRC-1:0] irq_mask,
    input logic [NCORE-1:0][NSRC-1:0] mchk_mask,
    input logic                       top_valid_q,
    input logic [IDX_W-1:0]           top_idx_q,
    input logic [NCORE-1:0]           core_irq_o,
    input logic [NCORE-1:0]           core_mchk_o
);
    // Edges since reset release, saturating, so that $past never reaches into reset.
    logic [1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_q <= '0;
        else if (since_q != 2'd3) since_q <= since_q + 2'd1;
    end

    assert_status_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 2'd3) |-> (status_q == $past(src_i, 3)));

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        assert_irq_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
            core_irq_o[c] == |$past(status_q & irq_mask[c]));
        assert_mchk_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
            core_mchk_o[c] == |$past(status_q & mchk_mask[c]));
    end

    assert_top_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid_q == |$past(status_q & irq_mask[0]));

    assert_top_highest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid_q |-> (($past(status_q & irq_mask[0]) >> top_idx_q) == NSRC'(1)));
endmodule

bind lvl_irq_router lvl_irq_router_chk #(.NSRC(NSRC), .NCORE(NCORE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .status_q    (status_q),
    .irq_mask    (irq_mask),
    .mchk_mask   (mchk_mask),
    .top_valid_q (top_valid_q),
    .top_idx_q   (top_idx_q),
    .core_irq_o  (core_irq_o),
    .core_mchk_o (core_mchk_o)
);

// File: tb/lvl_irq_router_bench.sv
`timescale 1ns/1ps
module lvl_irq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  core_irq_o;
    logic [1:0]  core_mchk_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    lvl_irq_router u_lvl_irq_router (
        .clk (clk), .rst_n (rst_n), .src_i (src_i),
        .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .core_irq_o (core_irq_o), .core_mchk_o (core_mchk_o)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] mi0;
        logic [31:0] mi1;
        logic [31:0] mc0;
        logic [31:0] mc1;
        logic [1:0]  eirq;
        logic [1:0]  emc;
        logic [5:0]  etop;
    } vec_t;

    localparam vec_t VECS [0:6] = '{
        '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0,         32'h0,         32'h0,         2'b01, 2'b00, 6'h20},
        '{32'h8000_0001, 32'h0000_0001, 32'h8000_0000, 32'h0,         32'h0,         2'b11, 2'b00, 6'h20},
        '{32'h0001_0100, 32'hFFFF_FFFF, 32'h0,         32'h0000_0100, 32'h0,         2'b01, 2'b01, 6'h30},
        '{32'h0000_0F00, 32'h0000_00FF, 32'h0000_F000, 32'h0,         32'h0000_0800, 2'b00, 2'b10, 6'h00},
        '{32'h0000_0040, 32'h0000_0040, 32'h0000_0040, 32'h0000_0040, 32'h0000_0040, 2'b11, 2'b11, 6'h26},
        '{32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0,         32'h0,         32'h0,         2'b01, 2'b00, 6'h3E},
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 2'b00, 6'h00}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // All driving happens just after a falling edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired got=hung exp=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        step(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq lines", {30'd0, core_irq_o}, 32'h0);
        check("R1 mchk lines", {30'd0, core_mchk_o}, 32'h0);
        for (int a = 'h10; a <= 'h1C; a += 4) begin
            rd(8'(a), r);
            check("R1 mask reset", r, 32'h0);
        end
        rd(8'h20, r);
        check("R1 top word", r, 32'h0);

        // Vector table: R4 R5 R6 R7 R2
        foreach (VECS[k]) begin
            wr(8'h10, VECS[k].mi0);
            wr(8'h14, VECS[k].mi1);
            wr(8'h18, VECS[k].mc0);
            wr(8'h1C, VECS[k].mc1);
            src_i = VECS[k].src;
            step(5);
            check("R4 irq vector", {30'd0, core_irq_o}, {30'd0, VECS[k].eirq});
            check("R5 mchk vector", {30'd0, core_mchk_o}, {30'd0, VECS[k].emc});
            rd(8'h20, r);
            check("R7 top vector", r, {26'd0, VECS[k].etop});
            rd(8'h00, r);
            check("R2 status vector", r, VECS[k].src);
        end

        // R3: mask readback
        wr(8'h10, 32'hA5A5_0001);
        wr(8'h14, 32'h1234_5678);
        wr(8'h18, 32'h0F0F_F0F0);
        wr(8'h1C, 32'hDEAD_BEEF);
        rd(8'h10, r); check("R3 irq mask core0", r, 32'hA5A5_0001);
        rd(8'h14, r); check("R3 irq mask core1", r, 32'h1234_5678);
        rd(8'h18, r); check("R3 mchk mask core0", r, 32'h0F0F_F0F0);
        rd(8'h1C, r); check("R3 mchk mask core1", r, 32'hDEAD_BEEF);

        // R8: undefined offsets ignored and read zero
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h11, 32'hFFFF_FFFF);
        rd(8'h10, r); check("R8 irq mask0 untouched", r, 32'hA5A5_0001);
        rd(8'h1C, r); check("R8 mchk mask1 untouched", r, 32'hDEAD_BEEF);
        rd(8'h04, r); check("R8 undefined read", r, 32'h0);
        rd(8'h24, r); check("R8 undefined read hi", r, 32'h0);

        // R6 + R2/R4 timing: one source through all four masks, change lands on one edge
        wr(8'h10, 32'h0000_0200);
        wr(8'h14, 32'h0000_0200);
        wr(8'h18, 32'h0000_0200);
        wr(8'h1C, 32'h0000_0200);
        src_i = 32'h0;
        step(5);
        src_i = 32'h0000_0200;
        step(2);
        rd(8'h00, r); check("R2 status before capture", r, 32'h0);
        step(1);
        rd(8'h00, r); check("R2 status at capture", r, 32'h0000_0200);
        check("R6 lines still low", {28'd0, core_irq_o, core_mchk_o}, 32'h0);
        rd(8'h20, r); check("R7 top still idle", r, 32'h0);
        step(1);
        check("R6 all lines same edge", {28'd0, core_irq_o, core_mchk_o}, 32'hF);
        rd(8'h20, r); check("R7 top same edge", r, 32'h29);

        // R2: writes to status ignored
        wr(8'h00, 32'h0);
        rd(8'h00, r); check("R2 status write ignored", r, 32'h0000_0200);

        // R9: level hold, no acknowledge, clear on source drop
        step(10);
        check("R9 held while source high", {28'd0, core_irq_o, core_mchk_o}, 32'hF);
        src_i = 32'h0;
        step(3);
        check("R9 before source-drop edge", {28'd0, core_irq_o, core_mchk_o}, 32'hF);
        step(1);
        check("R9 cleared by source drop", {28'd0, core_irq_o, core_mchk_o}, 32'h0);

        // R9 / R4: clear by mask write, two edges after the write is applied
        src_i = 32'h0000_0200;
        step(5);
        bus_addr = 8'h10; bus_wdata = 32'h0; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
        check("R4 one edge after mask write", {30'd0, core_irq_o}, 32'h3);
        step(1);
        check("R9 cleared by mask", {30'd0, core_irq_o}, 32'h2);
        check("R5 mchk unaffected", {30'd0, core_mchk_o}, 32'h3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule